// File: doc/BRIEF.md
# Dual-line game pad input replayer

This block stands in for serial game pads on one console controller port. The host drives a shared latch line and a shared clock line. The block answers on two data lines, and each line carries its own 16-bit word. The words come from an upstream FIFO. Each FIFO entry holds one word per data line, so a port can carry two controllers' worth of data. The host lines are synchronised into the system clock domain before the block acts on them. The block reacts to the latch falling edge and to the rising edges of the pad clock.

The block has two sequencing modes, chosen by a mode pin. In frame mode, a free-running timer marks video-frame boundaries. The first poll after a boundary takes a new word set from the FIFO. Any further poll in the same frame serves that word set again, so a host that polls irregularly still sees one input per frame. In poll mode, every latch takes a new word set, whatever the timing. The host may poll several times per frame, clock more than 16 bits, or hold the latch high for a long time, and the block stays in step through all of these.

Top module: `pad_replayer`

## Requirements
- R1: While reset is asserted and on the cycle after it, both data lines are high, `fifo_pop_o` is low and `underflow_o` is low.
- R2: After a latch falling edge, each data line shows bit 0 of its word. After the n-th pad clock rising edge it shows bit n, for n = 0 to 15 (LSB first). The outputs are active low: a 1 bit drives the line low.
- R3: Data line 0 serves bits [15:0] of the FIFO entry and data line 1 serves bits [31:16]. The two lines shift together from the shared latch and clock lines.
- R4: After 16 pad clock rising edges with no new latch, both lines hold high through any number of further clocks. The lines change only in the cycle after a synchronised latch or pad clock event.
- R5: In poll mode (mode pin = 1), every latch falling edge pops exactly one FIFO entry and serves it.
- R6: In frame mode (mode pin = 0), the first latch after reset or after a frame boundary (every FRAME_CYCLES clocks) pops one entry. Later latches in the same frame re-serve the same word set without popping.
- R7: The mode pin is sampled at the latch rising edge. A change made while the latch is high has no effect on that poll.
- R8: While the latch is held high, no entry is popped, pad clocks are ignored, and the lines show bit 0 of the word set currently held.
- R9: When a pop is due but the FIFO is empty, nothing is popped, the last word set is served again, and `underflow_o` goes high. It returns low after the next successful pop.
- R10: `fifo_pop_o` is a single-cycle pulse, at most one per latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0 = frame-synchronised replay, 1 = new word set on every latch |
| pad_latch_i | input | 1 | Host latch line (asynchronous) |
| pad_clk_i | input | 1 | Host pad clock line (asynchronous) |
| pad_data_o | output | NUM_LINES | Active-low serial data lines |
| fifo_data_i | input | NUM_LINES*WORD_W | Head entry of the upstream FIFO, line 0 in the low bits |
| fifo_empty_i | input | 1 | Upstream FIFO has no entry |
| fifo_pop_o | output | 1 | Takes the head entry |
| underflow_o | output | 1 | A pop was due while the FIFO was empty |

## Verification
The bench builds the block with FRAME_CYCLES = 1000, so several frame boundaries fall within a few thousand cycles. It also uses the default two lines of 16 bits. At this size, every bit position of both lines is compared against the model on every poll, along with the extra clocks after bit 15. Polls are placed at chosen offsets within frames, which brings repeated polls in one frame, polls across a boundary, mode changes while the latch is high, a long-held latch and an exhausted FIFO all within reach of one short run.

// File: rtl/pad_replay_pkg.sv
package pad_replay_pkg;

    typedef enum logic {
        MODE_FRAME = 1'b0,
        MODE_POLL  = 1'b1
    } replay_mode_e;

    // Synchronised view of one host line
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } line_evt_t;

    // Active-low drive: set bit pulls low, inactive slot rests high
    function automatic logic drive_level(input logic bit_val, input logic active);
        return active ? ~bit_val : 1'b1;
    endfunction

endpackage

// File: rtl/pad_edge_sync.sv
module pad_edge_sync
    import pad_replay_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      async_i,
    output line_evt_t evt_o
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-1:0], async_i};
    end

    always_comb begin
        evt_o.level = pipe[STAGES-1];
        evt_o.rise  = pipe[STAGES-1] & ~pipe[STAGES];
        evt_o.fall  = ~pipe[STAGES-1] & pipe[STAGES];
    end
endmodule

// File: rtl/pad_frame_timer.sv
module pad_frame_timer #(
    parameter int FRAME_CYCLES = 833_333
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CNT_W = $clog2(FRAME_CYCLES);
    logic [CNT_W-1:0] cnt;

    assign tick_o = (cnt == CNT_W'(FRAME_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst || tick_o) cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pad_shift_line.sv
module pad_shift_line
    import pad_replay_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              shift_i,
    output logic              data_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    logic [WORD_W-1:0] sr;
    logic [CNT_W-1:0]  cnt;
    logic              active;

    assign active = (cnt < CNT_W'(WORD_W));
    assign data_o = drive_level(sr[0], active);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr  <= '0;
            cnt <= CNT_W'(WORD_W);
        end else if (load_i) begin
            sr  <= word_i;
            cnt <= '0;
        end else if (shift_i && active) begin
            sr  <= sr >> 1;
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pad_replayer.sv
module pad_replayer
    import pad_replay_pkg::*;
#(
    parameter int WORD_W       = 16,
    parameter int NUM_LINES    = 2,
    parameter int FRAME_CYCLES = 833_333,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        mode_i,
    input  logic                        pad_latch_i,
    input  logic                        pad_clk_i,
    output logic [NUM_LINES-1:0]        pad_data_o,
    input  logic [NUM_LINES*WORD_W-1:0] fifo_data_i,
    input  logic                        fifo_empty_i,
    output logic                        fifo_pop_o,
    output logic                        underflow_o
);
    localparam int SET_W = NUM_LINES * WORD_W;

    line_evt_t    lat_e, pclk_e;
    logic         frame_tick, frame_due, want_new, pop;
    replay_mode_e mode_q;
    logic [SET_W-1:0] cur_set, next_set;

    pad_edge_sync #(.STAGES(SYNC_STAGES)) u_lat_sync (
        .clk(clk), .rst(rst), .async_i(pad_latch_i), .evt_o(lat_e));
    pad_edge_sync #(.STAGES(SYNC_STAGES)) u_clk_sync (
        .clk(clk), .rst(rst), .async_i(pad_clk_i), .evt_o(pclk_e));
    pad_frame_timer #(.FRAME_CYCLES(FRAME_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .tick_o(frame_tick));

    assign want_new   = (mode_q == MODE_POLL) || frame_due;
    assign pop        = lat_e.fall && want_new && !fifo_empty_i;
    assign fifo_pop_o = pop;
    assign next_set   = pop ? fifo_data_i : cur_set;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= MODE_FRAME;
            frame_due   <= 1'b1;
            cur_set     <= '0;
            underflow_o <= 1'b0;
        end else begin
            if (lat_e.rise) mode_q <= replay_mode_e'(mode_i);
            if (frame_tick)  frame_due <= 1'b1;
            else if (pop)    frame_due <= 1'b0;
            if (lat_e.fall) begin
                cur_set <= next_set;
                if (pop)           underflow_o <= 1'b0;
                else if (want_new) underflow_o <= 1'b1;
            end
        end
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        pad_shift_line #(.WORD_W(WORD_W)) u_line (
            .clk    (clk),
            .rst    (rst),
            .load_i (lat_e.level | lat_e.fall),
            .word_i (lat_e.fall ? next_set[g*WORD_W +: WORD_W]
                                : cur_set[g*WORD_W +: WORD_W]),
            .shift_i(pclk_e.rise & ~lat_e.level),
            .data_o (pad_data_o[g])
        );
    end
endmodule

// File: rtl/pad_replayer_chk.sv
module pad_replayer_chk
    import pad_replay_pkg::*;
#(
    parameter int NUM_LINES = 2
) (
    input logic                 clk,
    input logic                 rst,
    input line_evt_t            lat_e,
    input line_evt_t            pclk_e,
    input logic [NUM_LINES-1:0] pad_data_o,
    input logic                 fifo_empty_i,
    input logic                 fifo_pop_o,
    input logic                 underflow_o
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (pad_data_o == '1 && !fifo_pop_o && !underflow_o));
    // R9
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_pop_o |-> !fifo_empty_i);
    // R9
    underflow_clear_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_pop_o |=> !underflow_o);
    // R10
    single_pop_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_pop_o |=> !fifo_pop_o);
    // R8
    no_pop_high_chk: assert property (@(posedge clk) disable iff (rst)
        lat_e.level |-> !fifo_pop_o);
    // R4
    quiet_lines_chk: assert property (@(posedge clk) disable iff (rst)
        (!lat_e.level && !lat_e.fall && !lat_e.rise && !pclk_e.rise && !pclk_e.fall
         && !pclk_e.level) |=> $stable(pad_data_o));
endmodule

bind pad_replayer pad_replayer_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk(clk), .rst(rst), .lat_e(lat_e), .pclk_e(pclk_e),
    .pad_data_o(pad_data_o), .fifo_empty_i(fifo_empty_i),
    .fifo_pop_o(fifo_pop_o), .underflow_o(underflow_o));

// File: tb/pad_replayer_test.sv
module pad_replayer_test;
    localparam int W = 16;
    localparam int FRAME = 1000;

    logic clk = 1'b0, rst = 1'b1;
    logic mode_i = 1'b0, lat = 1'b0, pclk = 1'b0;
    logic [1:0]  pad_data;
    logic [31:0] fifo_data;
    logic        fifo_empty, fifo_pop, underflow;
    logic [31:0] mem [0:15];
    logic [4:0]  head = '0, fill = 5'd6;
    int cyc = 0, checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign fifo_empty = (head >= fill);
    assign fifo_data  = mem[head[3:0]];

    always @(posedge clk) begin
        if (rst) cyc <= 0; else cyc <= cyc + 1;
        if (!rst && fifo_pop) head <= head + 1'b1;
    end

    pad_replayer #(.WORD_W(W), .NUM_LINES(2), .FRAME_CYCLES(FRAME)) uut (
        .clk(clk), .rst(rst), .mode_i(mode_i), .pad_latch_i(lat),
        .pad_clk_i(pclk), .pad_data_o(pad_data), .fifo_data_i(fifo_data),
        .fifo_empty_i(fifo_empty), .fifo_pop_o(fifo_pop), .underflow_o(underflow));

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // One poll: latch, 16 bits on both lines, three extra clocks
    task automatic do_poll(input int idx, input int exp_pops, input string req,
                           input int hold, input bit flip);
        logic [15:0] got0, got1;
        logic [4:0]  h0;
        h0 = head;
        lat = 1'b1;
        wait_n(4);
        if (flip) mode_i = ~mode_i;
        for (int k = 4; k < hold; k += 8) begin
            pclk = 1'b1; wait_n(4); pclk = 1'b0; wait_n(4);
        end
        if (hold > 4) // R8 bit 0 of held set during long latch, no pop
            chk(pad_data == ~{mem[idx][16], mem[idx][0]} && head == h0,
                "R8", {30'd0, pad_data}, {30'd0, ~{mem[idx][16], mem[idx][0]}});
        lat = 1'b0;
        wait_n(4);
        for (int i = 0; i < W; i++) begin
            got0[i] = ~pad_data[0];
            got1[i] = ~pad_data[1];
            pclk = 1'b1; wait_n(4); pclk = 1'b0; wait_n(4);
        end
        chk(got0 == mem[idx][15:0], {req, " R2 line0"}, {16'd0, got0}, {16'd0, mem[idx][15:0]});
        chk(got1 == mem[idx][31:16], {req, " R3 line1"}, {16'd0, got1}, {16'd0, mem[idx][31:16]});
        chk(int'(head - h0) == exp_pops, {req, " pops R10"}, 32'(head - h0), 32'(exp_pops));
        for (int e = 0; e < 3; e++) begin
            pclk = 1'b1; wait_n(4); pclk = 1'b0; wait_n(4);
            chk(pad_data == 2'b11, "R4 idle high", {30'd0, pad_data}, 32'd3);
        end
    endtask

    initial begin
        for (int k = 0; k < 16; k++)
            mem[k] = {16'(16'hA5C3 ^ (k * 16'h1357)), 16'(16'h0001 << k) | 16'h8000};
        wait_n(5);
        // R1 reset state
        chk(pad_data == 2'b11, "R1 lines", {30'd0, pad_data}, 32'd3);
        chk(!fifo_pop && !underflow, "R1 flags", {30'd0, fifo_pop, underflow}, 32'd0);
        rst = 1'b0;
        wait_n(2);
        chk(pad_data == 2'b11, "R1 after reset", {30'd0, pad_data}, 32'd3);
        // R6 frame mode
        wait_until(20);   do_poll(0, 1, "R6 first", 4, 0);
        wait_until(300);  do_poll(0, 0, "R6 repeat", 4, 0);
        wait_until(550);  do_poll(0, 0, "R8 hold", 44, 0);
        wait_until(1100); do_poll(1, 1, "R6 next frame", 4, 0);
        // R7 mode flipped while latch high: still frame rule this poll
        wait_until(1400); do_poll(1, 0, "R7 flip", 4, 1);
        chk(mode_i == 1'b1, "R7 mode pin", {31'd0, mode_i}, 32'd1);
        // R5 poll mode
        wait_until(1700); do_poll(2, 1, "R5 a", 4, 0);
        do_poll(3, 1, "R5 b", 4, 0);
        do_poll(4, 1, "R5 c", 4, 0);
        do_poll(5, 1, "R5 d", 4, 0);
        // R9 empty FIFO
        do_poll(5, 0, "R9 empty", 4, 0);
        chk(underflow == 1'b1, "R9 underflow set", {31'd0, underflow}, 32'd1);
        do_poll(5, 0, "R9 still empty", 4, 0);
        chk(underflow == 1'b1, "R9 underflow held", {31'd0, underflow}, 32'd1);
        fill = 5'd8;
        do_poll(6, 1, "R9 refill", 4, 0);
        chk(underflow == 1'b0, "R9 underflow clear", {31'd0, underflow}, 32'd0);
        // back to frame mode in a fresh frame
        mode_i = 1'b0;
        wait_until(((cyc / FRAME) + 1) * FRAME + 100);
        do_poll(7, 1, "R6 boundary", 4, 0);
        do_poll(7, 0, "R6 same frame", 4, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule